// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

This block is one channel of a timer. It holds a programmable start value. While the channel is enabled, the count steps down by one on each selected tick. After the count reaches zero, the next tick wraps it back to the start value. One full period therefore takes start value plus one ticks. Ticks come either from a tick derived from the APB clock or from an external 1 MHz tick, and both arrive as single-cycle enables in the system clock domain.

Two compare registers mark points inside each period, and the hardware sorts them every cycle. A compare value at or above the start value acts as zero. An event is raised when the count reaches the larger compare point, again at the smaller one, and at zero when the overflow control asks for it or when either compare register holds zero. Each event inverts the interrupt level, which suits an edge-sensitive interrupt controller. Each event also gives a single-cycle pulse that a shared status register uses to set this channel's bit.

Software writes the count, the start value and the two compare values through separate strobes that share one data bus. The block does no bus decoding and has no shared control register.

Top module: `dmt_timer_channel`

## Requirements
- R1: While running with a nonzero start value, each selected tick lowers the count by one. A tick that finds the count at zero reloads the start value, so one period is start value plus one ticks.
- R2: With `clk_sel_ext`=1 only `ext_tick` advances the count. With `clk_sel_ext`=0 only `apb_tick` advances it. The other tick input has no effect.
- R3: `count` shows the live count while the channel is enabled and the start value while it is disabled. Ticks do not change the count while the channel is disabled. A 0-to-1 change of `enable` restarts counting from the start value, which `count` shows at the next edge.
- R4: A compare register whose value is greater than or equal to the start value counts as an effective compare value of zero.
- R5: A tick that moves the count onto a nonzero effective compare value raises one event. The order of the two registers does not matter, and two equal compare values raise only one event.
- R6: A tick that moves the count onto zero raises an event only if `ovf_irq_en`=1 or either compare register holds zero. A tick that wraps from zero back to the start value raises no event.
- R7: Each event inverts `irq_level` and drives `irq_set` high for exactly one cycle. Both changes appear at the same clock edge where the count takes its new value. With no event, `irq_level` holds its value.
- R8: A count write while enabled loads `wr_data` at the next edge, overrides a tick in the same cycle and raises no event. A count write while disabled has no effect.
- R9: A compare write takes effect for the very next tick.
- R10: Writing a nonzero start value while enabled loads it into the count only if the previous start value was zero. Otherwise the count continues unchanged.
- R11: While enabled with a start value of zero, the count stays at zero, count writes are ignored and no events occur.
- R12: After reset the start value, both compare registers, the count and `irq_level` are zero, `irq_set` is low and the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel run control |
| clk_sel_ext | input | 1 | 1 selects the external tick, 0 selects the APB tick |
| ovf_irq_en | input | 1 | Raise an event when the count reaches zero |
| apb_tick | input | 1 | Single-cycle tick derived from the APB clock |
| ext_tick | input | 1 | Single-cycle external 1 MHz tick |
| wr_count | input | 1 | Write strobe for the live count |
| wr_reload | input | 1 | Write strobe for the start value |
| wr_match_a | input | 1 | Write strobe for compare register A |
| wr_match_b | input | 1 | Write strobe for compare register B |
| wr_data | input | CNT_W | Write data shared by all strobes |
| count | output | CNT_W | Live count when enabled, start value when disabled |
| irq_level | output | 1 | Interrupt level, inverted on every event |
| irq_set | output | 1 | One-cycle pulse per event for the shared status bit |

## Verification
The bench programs the compare registers in both orders and with equal values. A design that sorts them wrongly or counts a duplicate twice shows the wrong number of `irq_set` pulses per period. Compare values equal to or above the start value are used to catch a design that fires at a count it can never reach or that drops the zero-collapse rule. The zero event is checked with the overflow control off and the compare registers nonzero, which exposes a design that fires on every zero, and with one compare register at zero, which exposes one that ignores it. The bench also covers a zero start value, a count write that lands on a tick, a count write while disabled, and the rule that only a previous start value of zero lets a new one restart the count. Errors there show up as a count that moves when it should hold, or holds when it should load.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  typedef enum logic {
    SRC_APB = 1'b0,
    SRC_EXT = 1'b1
  } tick_src_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_HIGH = 2'd1,
    EV_LOW  = 2'd2,
    EV_ZERO = 2'd3
  } ev_kind_e;

  localparam int unsigned NUM_CMP = 2;

endpackage

// File: rtl/dmt_tick_sel.sv
module dmt_tick_sel
  import dmt_pkg::*;
(
  input  logic clk_sel_ext,
  input  logic apb_tick,
  input  logic ext_tick,
  output logic tick
);

  tick_src_e src;

  always_comb begin
    src  = tick_src_e'(clk_sel_ext);
    tick = (src == SRC_EXT) ? ext_tick : apb_tick;
  end

endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             wr_count,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             run_q,
  output logic             step
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic             en_q;
  logic             en_rise;
  logic             run;
  logic             reload_zero;
  logic             wrap;
  logic [CNT_W-1:0] cnt_d;

  function automatic logic [CNT_W-1:0] dec_or_wrap(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] start
  );
    return (cur == ZERO) ? start : (cur - ONE);
  endfunction

  assign en_rise     = enable & ~en_q;
  assign run         = enable & en_q;
  assign reload_zero = (reload_q == ZERO);
  assign step        = run & tick & ~wr_count & ~reload_zero & (cnt_q != ZERO);
  assign wrap        = run & tick & ~wr_count & ~reload_zero & (cnt_q == ZERO);
  assign run_q       = en_q;

  always_comb begin
    cnt_d = cnt_q;
    if (en_rise) begin
      cnt_d = reload_q;
    end else if (run) begin
      if (reload_zero) begin
        cnt_d = wr_reload ? wr_data : ZERO;
      end else if (wr_count) begin
        cnt_d = wr_data;
      end else if (tick) begin
        cnt_d = dec_or_wrap(cnt_q, reload_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      cnt_q    <= ZERO;
      reload_q <= ZERO;
    end else begin
      en_q  <= enable;
      cnt_q <= cnt_d;
      if (wr_reload) begin
        reload_q <= wr_data;
      end
    end
  end

  p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == $past(cnt_q) - ONE));

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == $past(reload_q)));

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (cnt_q == $past(reload_q)));

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(cnt_q));

  p_zero_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && reload_zero && !wr_reload) |=> (cnt_q == ZERO));

endmodule

// File: rtl/dmt_match_order.sv
module dmt_match_order
  import dmt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_match_a,
  input  logic             wr_match_b,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] reload_q,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             step,
  input  logic             ovf_irq_en,
  output ev_kind_e         ev_kind,
  output logic             fire
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [NUM_CMP-1:0]            wr_cmp;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_eff;
  logic [NUM_CMP-1:0]            cmp_raw_zero;
  logic [CNT_W-1:0]              hi_eff;
  logic [CNT_W-1:0]              lo_eff;
  logic [CNT_W-1:0]              nxt;
  logic                          hi_hit;
  logic                          lo_hit;
  logic                          zero_hit;

  function automatic logic [CNT_W-1:0] collapse(
    input logic [CNT_W-1:0] m,
    input logic [CNT_W-1:0] start
  );
    return (m < start) ? m : ZERO;
  endfunction

  function automatic logic [CNT_W-1:0] larger(
    input logic [CNT_W-1:0] x,
    input logic [CNT_W-1:0] y
  );
    return (x > y) ? x : y;
  endfunction

  function automatic logic [CNT_W-1:0] smaller(
    input logic [CNT_W-1:0] x,
    input logic [CNT_W-1:0] y
  );
    return (x > y) ? y : x;
  endfunction

  assign wr_cmp = {wr_match_b, wr_match_a};

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[g] <= ZERO;
      end else if (wr_cmp[g]) begin
        cmp_q[g] <= wr_data;
      end
    end
    assign cmp_eff[g]      = collapse(cmp_q[g], reload_q);
    assign cmp_raw_zero[g] = (cmp_q[g] == ZERO);
  end

  assign hi_eff = larger(cmp_eff[0], cmp_eff[1]);
  assign lo_eff = smaller(cmp_eff[0], cmp_eff[1]);
  assign nxt    = cnt_q - ONE;

  assign hi_hit   = step & (hi_eff != ZERO) & (nxt == hi_eff);
  assign lo_hit   = step & (lo_eff != ZERO) & (lo_eff != hi_eff) & (nxt == lo_eff);
  assign zero_hit = step & (nxt == ZERO) & (ovf_irq_en | (|cmp_raw_zero));

  always_comb begin
    ev_kind = EV_NONE;
    if (hi_hit) begin
      ev_kind = EV_HIGH;
    end else if (lo_hit) begin
      ev_kind = EV_LOW;
    end else if (zero_hit) begin
      ev_kind = EV_ZERO;
    end
  end

  assign fire = (ev_kind != EV_NONE);

  p_single_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_hit, lo_hit, zero_hit}));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> !fire);

  p_zero_start_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q == ZERO) |-> !fire);

endmodule

// File: rtl/dmt_irq_out.sv
module dmt_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic irq_level,
  output logic irq_set
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level <= 1'b0;
      irq_set   <= 1'b0;
    end else begin
      irq_set <= fire;
      if (fire) begin
        irq_level <= ~irq_level;
      end
    end
  end

  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> (irq_level != $past(irq_level)));

  p_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_set |-> $stable(irq_level));

endmodule

// File: rtl/dmt_timer_channel.sv
module dmt_timer_channel
  import dmt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clk_sel_ext,
  input  logic             ovf_irq_en,
  input  logic             apb_tick,
  input  logic             ext_tick,
  input  logic             wr_count,
  input  logic             wr_reload,
  input  logic             wr_match_a,
  input  logic             wr_match_b,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             irq_level,
  output logic             irq_set
);

  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;
  logic             run_q;
  logic             step;
  ev_kind_e         ev_kind;
  logic             fire;

  dmt_tick_sel u_tick_sel (
    .clk_sel_ext (clk_sel_ext),
    .apb_tick    (apb_tick),
    .ext_tick    (ext_tick),
    .tick        (tick)
  );

  dmt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (tick),
    .wr_count  (wr_count),
    .wr_reload (wr_reload),
    .wr_data   (wr_data),
    .cnt_q     (cnt_q),
    .reload_q  (reload_q),
    .run_q     (run_q),
    .step      (step)
  );

  dmt_match_order #(.CNT_W(CNT_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_match_a (wr_match_a),
    .wr_match_b (wr_match_b),
    .wr_data    (wr_data),
    .reload_q   (reload_q),
    .cnt_q      (cnt_q),
    .step       (step),
    .ovf_irq_en (ovf_irq_en),
    .ev_kind    (ev_kind),
    .fire       (fire)
  );

  dmt_irq_out u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .irq_level (irq_level),
    .irq_set   (irq_set)
  );

  assign count = run_q ? cnt_q : reload_q;

  p_event_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> $past(step));

endmodule

// File: tb/test_dmt_timer_channel.sv
module test_dmt_timer_channel;

  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic         clk_sel_ext = 1'b0;
  logic         ovf_irq_en = 1'b0;
  logic         apb_tick = 1'b0;
  logic         ext_tick = 1'b0;
  logic         wr_count = 1'b0;
  logic         wr_reload = 1'b0;
  logic         wr_match_a = 1'b0;
  logic         wr_match_b = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count;
  logic         irq_level;
  logic         irq_set;

  int checks = 0;
  int errors = 0;
  bit exp_lvl = 1'b0;

  always #10 clk = ~clk;

  dmt_timer_channel #(.CNT_W(W)) i_dmt_timer_channel (
    .clk, .rst_n, .enable, .clk_sel_ext, .ovf_irq_en, .apb_tick, .ext_tick,
    .wr_count, .wr_reload, .wr_match_a, .wr_match_b, .wr_data,
    .count, .irq_level, .irq_set
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input longint act, input longint exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wreg(input int which, input logic [W-1:0] d);
    wr_data = d;
    case (which)
      0: wr_count   = 1'b1;
      1: wr_reload  = 1'b1;
      2: wr_match_a = 1'b1;
      default: wr_match_b = 1'b1;
    endcase
    @(negedge clk);
    {wr_count, wr_reload, wr_match_a, wr_match_b} = '0;
  endtask

  task automatic set_en(input bit v);
    enable = v;
    @(negedge clk);
  endtask

  task automatic tick_n(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      if (clk_sel_ext) ext_tick = 1'b1; else apb_tick = 1'b1;
      @(negedge clk);
      apb_tick = 1'b0;
      ext_tick = 1'b0;
      if (irq_set) pulses++;
    end
  endtask

  task automatic setup(input logic [W-1:0] rl, input logic [W-1:0] a,
                       input logic [W-1:0] b, input bit ovf);
    set_en(1'b0);
    ovf_irq_en = ovf;
    wreg(1, rl);
    wreg(2, a);
    wreg(3, b);
    set_en(1'b1);
  endtask

  task automatic t_reset();
    chk_eq("R12 count", count, 0);
    chk_eq("R12 level", irq_level, 0);
    chk_eq("R12 set", irq_set, 0);
  endtask

  task automatic t_basic();
    int p;
    setup(5, 0, 0, 1'b0);
    chk_eq("R3 start shows reload", count, 5);
    tick_n(5, p);
    chk_eq("R1 reach zero", count, 0);
    chk_eq("R6 zero event via zero compare", p, 1);
    chk_eq("R7 pulse on zero tick", irq_set, 1);
    exp_lvl ^= 1'b1;
    chk_eq("R7 level toggled", irq_level, exp_lvl);
    tick_n(1, p);
    chk_eq("R1 wrap to reload", count, 5);
    chk_eq("R6 no event on wrap", p, 0);
    idle();
    chk_eq("R7 pulse one cycle", irq_set, 0);
  endtask

  task automatic t_source();
    int p;
    clk_sel_ext = 1'b0;
    ext_tick = 1'b1; idle(); ext_tick = 1'b0;
    chk_eq("R2 ext ignored on apb", count, 5);
    clk_sel_ext = 1'b1;
    apb_tick = 1'b1; idle(); apb_tick = 1'b0;
    chk_eq("R2 apb ignored on ext", count, 5);
    tick_n(1, p);
    chk_eq("R2 ext advances", count, 4);
    clk_sel_ext = 1'b0;
  endtask

  task automatic t_order();
    int p;
    setup(10, 3, 7, 1'b0);
    tick_n(3, p);
    chk_eq("R5 count at high", count, 7);
    chk_eq("R5 event at high", irq_set, 1);
    tick_n(4, p);
    chk_eq("R5 event at low", irq_set, 1);
    chk_eq("R5 count at low", count, 3);
    tick_n(3, p);
    chk_eq("R6 no zero event", p, 0);
    tick_n(1, p);
    chk_eq("R1 wrap period", count, 10);
    setup(10, 7, 3, 1'b0);
    tick_n(11, p);
    chk_eq("R5 swapped order", p, 2);
    setup(10, 4, 4, 1'b0);
    tick_n(11, p);
    chk_eq("R5 equal compares one event", p, 1);
    exp_lvl ^= 1'b1;
    chk_eq("R7 level after order runs", irq_level, exp_lvl);
  endtask

  task automatic t_collapse();
    int p;
    setup(10, 12, 5, 1'b0);
    tick_n(11, p);
    chk_eq("R4 above reload ignored", p, 1);
    setup(10, 10, 6, 1'b0);
    tick_n(4, p);
    chk_eq("R4 event at 6 only", irq_set, 1);
    tick_n(7, p);
    chk_eq("R4 equal reload collapses", p, 0);
    setup(10, 0, 4, 1'b0);
    tick_n(11, p);
    chk_eq("R6 zero compare adds zero event", p, 2);
    setup(10, 3, 7, 1'b1);
    tick_n(11, p);
    chk_eq("R6 overflow enable adds zero event", p, 3);
    exp_lvl ^= 1'b1;
    chk_eq("R7 level after collapse runs", irq_level, exp_lvl);
  endtask

  task automatic t_disable();
    int p;
    setup(10, 0, 0, 1'b0);
    tick_n(3, p);
    chk_eq("R1 partial", count, 7);
    set_en(1'b0);
    chk_eq("R3 disabled shows reload", count, 10);
    tick_n(2, p);
    chk_eq("R3 no events while disabled", p, 0);
    wreg(0, 2);
    set_en(1'b1);
    chk_eq("R8 disabled write ignored, restart", count, 10);
  endtask

  task automatic t_write_count();
    int p;
    wreg(0, 4);
    chk_eq("R8 count loaded", count, 4);
    chk_eq("R8 no event on write", irq_set, 0);
    wr_data = 8; wr_count = 1'b1; apb_tick = 1'b1;
    idle();
    wr_count = 1'b0; apb_tick = 1'b0;
    chk_eq("R8 write beats tick", count, 8);
  endtask

  task automatic t_match_write();
    int p;
    ovf_irq_en = 1'b0;
    wreg(2, 9);
    wreg(3, 9);
    wreg(2, 6);
    tick_n(1, p);
    chk_eq("R9 no event at 7", p, 0);
    tick_n(1, p);
    chk_eq("R9 new compare used", irq_set, 1);
    chk_eq("R9 count at 6", count, 6);
  endtask

  task automatic t_zero_start();
    int p;
    setup(0, 2, 2, 1'b1);
    chk_eq("R11 count zero", count, 0);
    tick_n(3, p);
    chk_eq("R11 held at zero", count, 0);
    chk_eq("R11 no events", p, 0);
    wreg(0, 5);
    chk_eq("R11 count write ignored", count, 0);
    wreg(1, 6);
    chk_eq("R10 start after zero loads", count, 6);
    wreg(1, 9);
    chk_eq("R10 later start leaves count", count, 6);
    tick_n(1, p);
    chk_eq("R10 continues counting", count, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle();
    t_reset();
    t_basic();
    t_source();
    t_order();
    t_collapse();
    t_disable();
    t_write_count();
    t_match_write();
    t_zero_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule